// File: doc/BRIEF.md
# Two-Wire Bus Error Monitor

This block sits next to the byte engine of a two-wire serial interface and watches the raw data and clock lines for START and STOP conditions. A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. The byte engine supplies a frame-phase signal. That signal is high from the first clock edge of a byte through its acknowledge bit. If a START or STOP appears while the frame-phase signal is high, the transfer is broken. The monitor then raises its interrupt flag, reports status code 00h, and stretches the bus clock low so the bus waits for software.

Software recovers by writing the control word with the stop-request bit set and the flag-clear bit set in the same write. The monitor then clears the flag and clears the stop-request bit by itself. It returns to the idle, not-addressed slave state and releases the clock line. No STOP condition is driven onto the bus. The acknowledge-enable control bit is written only by software and is never changed by recovery. While the flag is clear, the status reads F8h, meaning no state information is available.

Top module: `twi_buserr_mon`

## Requirements
- R1: After reset, `irq_flag` is 0, `status` is 8'hF8, `scl_low` is 0, `sto_bit` is 0 and `ack_en` is 0.
- R2: When `sda_in` falls while `scl_in` is high and `frame_active` is 1, `irq_flag` goes to 1 and `status` to 8'h00.
- R3: When `sda_in` rises while `scl_in` is high and `frame_active` is 1, `irq_flag` goes to 1 and `status` to 8'h00.
- R4: A START or STOP while `frame_active` is 0 is legal: `irq_flag` stays 0 and `status` stays 8'hF8.
- R5: A change of `sda_in` while `scl_in` is low is never a START or STOP, whatever `frame_active` is, so `irq_flag` stays 0.
- R6: While `irq_flag` is 1, further START or STOP conditions are ignored, and `status` stays 8'h00.
- R7: In the error state, a control write with `wr_flag_clr`=1 and `wr_sto`=0 does not recover: `irq_flag` stays 1. A write with `wr_sto`=1 and `wr_flag_clr`=0 only sets `sto_bit` to 1.
- R8: In the error state, a control write with `wr_sto`=1 and `wr_flag_clr`=1 makes `irq_flag` 0, `status` 8'hF8, `sto_bit` 0 and `scl_low` 0 at the next clock edge.
- R9: `scl_low` is 1 exactly while `irq_flag` is 1.
- R10: `ack_en` changes only on a control write, where it takes `wr_ack_en`; recovery leaves it as written.
- R11: The bus lines pass through a two-flop synchronizer. The flag rises at the third rising clock edge after the line change and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_in | input | 1 | Raw data line level |
| scl_in | input | 1 | Raw clock line level |
| frame_active | input | 1 | High from the first clock edge of a byte through its acknowledge bit |
| ctl_wr | input | 1 | Control write strobe |
| wr_sto | input | 1 | Stop-request value written |
| wr_flag_clr | input | 1 | 1 asks to clear the interrupt flag |
| wr_ack_en | input | 1 | Acknowledge-enable value written |
| irq_flag | output | 1 | Interrupt flag, set on a bus error |
| status | output | 8 | 8'h00 on a bus error, 8'hF8 otherwise |
| sto_bit | output | 1 | Stop-request bit; cleared by the monitor on recovery |
| ack_en | output | 1 | Acknowledge-enable bit |
| scl_low | output | 1 | 1 pulls the clock line low |

## Verification
Each error state shows at the ports at once. A missed or wrongly decoded condition leaves `irq_flag` and `status` wrong at the third edge after the line change. A synchronizer with the wrong depth moves that edge by one cycle. An error state that does not hold, or a recovery decoded badly, shows on the first cycle after the event or the write, through `irq_flag`, `sto_bit` or `scl_low`. The bench sweeps every combination of frame phase, clock level and data-edge direction. Every error case is taken through the hold, the partial writes and the full recovery.

// File: rtl/twi_mon_pkg.sv
package twi_mon_pkg;
  localparam logic [7:0] ST_NO_INFO = 8'hF8;
  localparam logic [7:0] ST_BUS_ERR = 8'h00;

  typedef enum logic {
    MON_IDLE  = 1'b0,
    MON_ERROR = 1'b1
  } mon_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_in;
    end else begin : g_next
      assign src = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= src;
    end
  end

  assign d_out = stg_q[STAGES-1];
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_s,
  input  logic scl_s,
  output logic start_evt,
  output logic stop_evt
);
  logic sda_prev_q, scl_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_prev_q <= 1'b1;
      scl_prev_q <= 1'b1;
    end else begin
      sda_prev_q <= sda_s;
      scl_prev_q <= scl_s;
    end
  end

  // START: data falls while the clock stays high; STOP: data rises likewise
  assign start_evt = sda_prev_q && !sda_s && scl_prev_q && scl_s;
  assign stop_evt  = !sda_prev_q && sda_s && scl_prev_q && scl_s;
endmodule

// File: rtl/twi_err_ctrl.sv
module twi_err_ctrl
  import twi_mon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_evt,
  input  logic stop_evt,
  input  logic frame_active,
  input  logic ctl_wr,
  input  logic wr_sto,
  input  logic wr_flag_clr,
  input  logic wr_ack_en,
  output logic irq_flag,
  output logic sto_bit,
  output logic ack_en,
  output logic scl_low
);
  mon_state_e state_q, state_d;
  logic       sto_q, sto_d, ack_q, ack_d;
  logic       illegal, recover, ctl_en;

  assign illegal = (start_evt || stop_evt) && frame_active;
  assign recover = ctl_wr && wr_flag_clr && wr_sto && (state_q == MON_ERROR);
  assign ctl_en  = ctl_wr || recover;

  always_comb begin
    state_d = state_q;
    case (state_q)
      MON_IDLE:  if (illegal) state_d = MON_ERROR;
      MON_ERROR: if (recover) state_d = MON_IDLE;
      default:   state_d = MON_IDLE;
    endcase
  end

  always_comb begin
    sto_d = sto_q;
    ack_d = ack_q;
    if (ctl_wr) begin
      sto_d = wr_sto;
      ack_d = wr_ack_en;
    end
    if (recover) sto_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MON_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sto_q <= 1'b0;
      ack_q <= 1'b0;
    end else if (ctl_en) begin
      sto_q <= sto_d;
      ack_q <= ack_d;
    end
  end

  assign irq_flag = (state_q == MON_ERROR);
  assign scl_low  = (state_q == MON_ERROR);
  assign sto_bit  = sto_q;
  assign ack_en   = ack_q;

  // R2
  illegal_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_flag && frame_active && (start_evt || stop_evt)) |=> irq_flag);
  // R4
  legal_keeps_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_flag && !frame_active) |=> !irq_flag);
  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !(ctl_wr && wr_flag_clr && wr_sto)) |=> irq_flag);
  // R8
  recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && ctl_wr && wr_flag_clr && wr_sto) |=> (!irq_flag && !sto_bit && !scl_low));
  // R10
  ack_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(ack_en));
endmodule

// File: rtl/twi_buserr_mon.sv
module twi_buserr_mon
  import twi_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_in,
  input  logic       scl_in,
  input  logic       frame_active,
  input  logic       ctl_wr,
  input  logic       wr_sto,
  input  logic       wr_flag_clr,
  input  logic       wr_ack_en,
  output logic       irq_flag,
  output logic [7:0] status,
  output logic       sto_bit,
  output logic       ack_en,
  output logic       scl_low
);
  logic [1:0] lines_s;
  logic       start_evt, stop_evt;

  twi_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({scl_in, sda_in}),
    .d_out (lines_s)
  );

  twi_cond_detect u_det (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (lines_s[0]),
    .scl_s     (lines_s[1]),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  twi_err_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_evt    (start_evt),
    .stop_evt     (stop_evt),
    .frame_active (frame_active),
    .ctl_wr       (ctl_wr),
    .wr_sto       (wr_sto),
    .wr_flag_clr  (wr_flag_clr),
    .wr_ack_en    (wr_ack_en),
    .irq_flag     (irq_flag),
    .sto_bit      (sto_bit),
    .ack_en       (ack_en),
    .scl_low      (scl_low)
  );

  assign status = irq_flag ? ST_BUS_ERR : ST_NO_INFO;

  // R1, R6
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag ? (status == 8'h00) : (status == 8'hF8));
  // R9
  scl_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_low == irq_flag);
endmodule

// File: tb/test_twi_buserr_mon.sv
module test_twi_buserr_mon;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       sda_in, scl_in, frame_active;
  logic       ctl_wr, wr_sto, wr_flag_clr, wr_ack_en;
  logic       irq_flag, sto_bit, ack_en, scl_low;
  logic [7:0] status;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  twi_buserr_mon i_twi_buserr_mon (
    .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in),
    .frame_active(frame_active), .ctl_wr(ctl_wr), .wr_sto(wr_sto),
    .wr_flag_clr(wr_flag_clr), .wr_ack_en(wr_ack_en), .irq_flag(irq_flag),
    .status(status), .sto_bit(sto_bit), .ack_en(ack_en), .scl_low(scl_low)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ctl_write(input logic sto, input logic clr, input logic ack);
    ctl_wr = 1'b1; wr_sto = sto; wr_flag_clr = clr; wr_ack_en = ack;
    @(negedge clk);
    ctl_wr = 1'b0; wr_sto = 1'b0; wr_flag_clr = 1'b0; wr_ack_en = 1'b0;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0; sda_in = 1'b1; scl_in = 1'b1; frame_active = 1'b0;
    ctl_wr = 1'b0; wr_sto = 1'b0; wr_flag_clr = 1'b0; wr_ack_en = 1'b0;
    wait_neg(3);
    rst_n = 1'b1;
    wait_neg(1);
    // R1 reset state
    check("R1 flag", {7'd0, irq_flag}, 8'd0);
    check("R1 status", status, 8'hF8);
    check("R1 scl_low", {7'd0, scl_low}, 8'd0);
    check("R1 sto", {7'd0, sto_bit}, 8'd0);
    check("R1 ack", {7'd0, ack_en}, 8'd0);

    // R10 ack_en written
    ctl_write(1'b0, 1'b0, 1'b1);
    check("R10 ack write", {7'd0, ack_en}, 8'd1);

    for (int fa = 0; fa < 2; fa++) begin
      for (int sh = 0; sh < 2; sh++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic exp_err;
          string tag;
          exp_err = (fa == 1) && (sh == 1);
          tag = (sh == 0) ? "R5" : (fa == 0) ? "R4" : (dir == 0) ? "R2" : "R3";
          scl_in = 1'b0;
          wait_neg(1);
          sda_in = (dir == 0) ? 1'b1 : 1'b0;
          wait_neg(1);
          scl_in = sh[0];
          frame_active = fa[0];
          wait_neg(4);
          check({tag, " pre"}, {7'd0, irq_flag}, 8'd0);
          sda_in = ~sda_in;
          wait_neg(2);
          // R11 not yet visible after two edges
          check("R11 early", {7'd0, irq_flag}, 8'd0);
          wait_neg(1);
          check({tag, " flag"}, {7'd0, irq_flag}, {7'd0, exp_err});
          check({tag, " status"}, status, exp_err ? 8'h00 : 8'hF8);
          check("R9 scl_low", {7'd0, scl_low}, {7'd0, exp_err});
          if (exp_err) begin
            // R6 opposite condition ignored
            sda_in = ~sda_in;
            wait_neg(4);
            check("R6 flag held", {7'd0, irq_flag}, 8'd1);
            check("R6 status held", status, 8'h00);
            // R7 partial writes
            ctl_write(1'b0, 1'b1, 1'b1);
            wait_neg(1);
            check("R7 clr only", {7'd0, irq_flag}, 8'd1);
            ctl_write(1'b1, 1'b0, 1'b1);
            check("R7 sto only sto", {7'd0, sto_bit}, 8'd1);
            check("R7 sto only flag", {7'd0, irq_flag}, 8'd1);
            check("R9 stretch", {7'd0, scl_low}, 8'd1);
            // R8 recovery
            ctl_write(1'b1, 1'b1, 1'b1);
            check("R8 flag", {7'd0, irq_flag}, 8'd0);
            check("R8 status", status, 8'hF8);
            check("R8 sto", {7'd0, sto_bit}, 8'd0);
            check("R8 scl_low", {7'd0, scl_low}, 8'd0);
            check("R10 ack kept", {7'd0, ack_en}, 8'd1);
          end else begin
            sda_in = ~sda_in;
            wait_neg(4);
            check({tag, " still clear"}, status, 8'hF8);
          end
          frame_active = 1'b0;
          wait_neg(2);
        end
      end
    end

    // R10 ack cleared by write only
    ctl_write(1'b0, 1'b0, 1'b0);
    check("R10 ack clear", {7'd0, ack_en}, 8'd0);

    done = 1'b1;
    report();
  end
endmodule